// File: doc/BRIEF.md
# PWM Controller with Sample FIFO

A single-channel pulse-width modulator controlled through a small 32-bit register port. A selectable clock source reaches the block as one clock-enable tick input. A 12-bit prescaler thins that tick stream into counting steps. A period counter runs for the programmed period plus two steps and then starts again. The output is high at the start of each period while the counter is below the active duty sample, and low for the rest of the period.

Software queues duty samples into a four-word FIFO. Each time a period starts, the controller takes one sample from the FIFO. Because of this, a new duty value takes effect only on a period boundary, and software can queue up to four periods ahead. A status register reports how full the FIFO is and holds a sticky flag for rejected writes. A self-clearing software reset flushes the FIFO and returns every register to its default value.

Top module: `pwm_fifo_ctrl`

## Requirements
- R1: After reset, every register reads its default value: control (0x00) reads 0, status (0x04) reads 0, the active sample (0x0C) reads 0, and period (0x10) reads 0xFFFE. Any other address reads 0.
- R2: The control register has these fields: enable in bit 0, prescaler-minus-one in [15:4], source select in [17:16], and four stored low-power enables in [25:22]. Each field reads back as written. Bits 1, 2 and all bits outside these fields read 0.
- R3: The sample FIFO holds 4 words, and status [2:0] gives the number of filled words. A write to offset 0x0C while the FIFO holds 4 words is dropped.
- R4: A dropped sample write sets status bit 4. The flag stays set until software writes status with bit 4 at 1. Writing status with bit 4 at 0 leaves it unchanged.
- R5: When the control value is P in [15:4], the counter advances once every P+1 input ticks. With period register N, one period lasts N+2 counter steps.
- R6: The output is high while the period counter is below the active sample. A sample of 0 gives a constant low output, and a sample of at least N+2 gives a constant high output.
- R7: A FIFO word is moved into the active sample on the first cycle after enable and at every period wrap. If the FIFO is empty at that moment, the previous sample is kept. Offset 0x0C reads the active sample.
- R8: Writing control with bit 3 at 1 flushes the FIFO, clears the overflow flag, the active sample and all control fields, and restores period 0xFFFE. Bit 3 then reads 1 for exactly 4 cycles and 0 afterwards.
- R9: While bit 3 reads 1, writes to the status, sample and period registers are ignored.
- R10: While enable is 0, the output is low and the prescaler and period counter are held at zero. The FIFO contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable tick from the selected source |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1 (with req_i) |
| addr_i | input | 5 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pwm_o | output | 1 | Modulated output |

## Verification
The duty path is tested with several sequences of distinct queued samples:
- A rising ramp with a single-cycle tick and prescaler 0. This shows whether each sample is taken at the right boundary, in queue order.
- A sample equal to the period length, which must give a constant high output once the queue runs dry. This separates "reuse the last sample" from "fall to zero".
- A zero sample, which must give a constant low output.
- A sparse tick (one in three) combined with prescaler 2. This shows whether the tick divider and the period divider combine correctly.

A model written from the requirements is compared with the output and the register reads on every cycle. Overflow, write-one-to-clear, the length of the reset pulse, writes made during the reset, and holding the FIFO while disabled each get their own directed checks.

// File: rtl/pwm_fifo_pkg.sv
`timescale 1ns/1ps
package pwm_fifo_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_SMPL = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_PER  = 5'h10;
  localparam int unsigned CTL_EN      = 0;
  localparam int unsigned CTL_SRST    = 3;
  localparam int unsigned CTL_PRE_LSB = 4;
  localparam int unsigned CTL_SRC_LSB = 16;
  localparam int unsigned CTL_LP_LSB  = 22;
  localparam int unsigned STAT_OVF    = 4;
endpackage

// File: rtl/pwm_sample_fifo.sv
`timescale 1ns/1ps
module pwm_sample_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 16,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [W-1:0]      din_i,
  output logic [W-1:0]      dout_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              empty_o,
  output logic              drop_o
);
  logic [W-1:0]      mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [FILL_W-1:0] fill_q;
  logic              do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // full/empty judged on the pre-edge fill
  assign do_push = push_i && (fill_q != FILL_W'(DEPTH));
  assign do_pop  = pop_i && (fill_q != '0);
  assign drop_o  = push_i && (fill_q == FILL_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      fill_q <= '0;
    end else if (flush_i) begin
      rd_q   <= '0;
      wr_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      fill_q <= fill_q + FILL_W'(do_push) - FILL_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign fill_o  = fill_q;
  assign empty_o = (fill_q == '0);
endmodule

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int unsigned PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] div_m1_i,
  output logic             step_o
);
  logic [PRE_W-1:0] cnt_q;

  // >= so a lowered divider takes effect at once
  assign step_o = run_i && tick_i && (cnt_q >= div_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= step_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_period_cnt.sv
`timescale 1ns/1ps
module pwm_period_cnt #(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned CTR_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             act_clr_i,
  input  logic             run_i,
  output logic             wrap_o,
  output logic [CTR_W-1:0] ctr_o,
  output logic [CNT_W-1:0] active_o,
  output logic             pwm_o
);
  logic [CTR_W-1:0] ctr_q, last;
  logic [CNT_W-1:0] act_q;

  // period length is register value + 2 steps
  assign last   = {1'b0, period_i} + 1'b1;
  assign wrap_o = step_i && (ctr_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctr_q <= '0;
    else if (clear_i) ctr_q <= '0;
    else if (step_i)  ctr_q <= wrap_o ? '0 : ctr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_q <= '0;
    else if (act_clr_i) act_q <= '0;
    else if (load_i)    act_q <= load_val_i;
  end

  assign pwm_o    = run_i && (ctr_q < {1'b0, act_q});
  assign ctr_o    = ctr_q;
  assign active_o = act_q;
endmodule

// File: rtl/pwm_fifo_ctrl.sv
`timescale 1ns/1ps
module pwm_fifo_ctrl
  import pwm_fifo_pkg::*;
#(
  parameter int unsigned        PRE_W    = 12,
  parameter int unsigned        CNT_W    = 16,
  parameter int unsigned        DEPTH    = 4,
  parameter int unsigned        SRST_CYC = 4,
  parameter logic [CNT_W-1:0]   PER_RST  = 16'hFFFE,
  localparam int unsigned       FILL_W   = $clog2(DEPTH + 1),
  localparam int unsigned       BCNT_W   = $clog2(SRST_CYC)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        pwm_o
);
  logic              en_q, run_q, busy_q, ovf_q;
  logic [PRE_W-1:0]  pre_q;
  logic [1:0]        src_q;
  logic [3:0]        lp_q;
  logic [CNT_W-1:0]  per_q;
  logic [BCNT_W-1:0] bcnt_q;

  logic              wr, ctl_wr, srst_go, reg_ok;
  logic              start, adv, ctr_clear, step, wrap;
  logic              push, pop, drop, empty, load;
  logic [CNT_W-1:0]  fifo_dout, active_w;
  logic [FILL_W-1:0] fill_w;
  logic [CNT_W:0]    ctr_w;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata_i[31:26], wdata_i[21:18], wdata_i[2:1]};

  assign wr      = req_i && we_i;
  assign ctl_wr  = wr && (addr_i == OFF_CTRL);
  assign srst_go = ctl_wr && wdata_i[CTL_SRST];
  assign reg_ok  = wr && !busy_q;

  // first cycle after enable loads a sample before counting
  assign start     = en_q && !run_q;
  assign adv       = en_q && run_q;
  assign ctr_clear = !en_q || start || srst_go;

  assign push = reg_ok && (addr_i == OFF_SMPL);
  assign pop  = (start || wrap) && !srst_go;
  assign load = pop && !empty;

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (ctr_clear),
    .run_i    (adv),
    .tick_i   (tick_i),
    .div_m1_i (pre_q),
    .step_o   (step)
  );

  pwm_sample_fifo #(.DEPTH(DEPTH), .W(CNT_W)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (srst_go),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (wdata_i[CNT_W-1:0]),
    .dout_o  (fifo_dout),
    .fill_o  (fill_w),
    .empty_o (empty),
    .drop_o  (drop)
  );

  pwm_period_cnt #(.CNT_W(CNT_W)) u_per (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (ctr_clear),
    .step_i     (step),
    .period_i   (per_q),
    .load_i     (load),
    .load_val_i (fifo_dout),
    .act_clr_i  (srst_go),
    .run_i      (adv),
    .wrap_o     (wrap),
    .ctr_o      (ctr_w),
    .active_o   (active_w),
    .pwm_o      (pwm_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pre_q  <= '0;
      src_q  <= '0;
      lp_q   <= '0;
      busy_q <= 1'b0;
      bcnt_q <= '0;
      per_q  <= PER_RST;
      ovf_q  <= 1'b0;
      run_q  <= 1'b0;
    end else if (srst_go) begin
      en_q   <= 1'b0;
      pre_q  <= '0;
      src_q  <= '0;
      lp_q   <= '0;
      busy_q <= 1'b1;
      bcnt_q <= BCNT_W'(SRST_CYC - 1);
      per_q  <= PER_RST;
      ovf_q  <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      run_q <= en_q;
      if (ctl_wr) begin
        en_q  <= wdata_i[CTL_EN];
        pre_q <= wdata_i[CTL_PRE_LSB +: PRE_W];
        src_q <= wdata_i[CTL_SRC_LSB +: 2];
        lp_q  <= wdata_i[CTL_LP_LSB +: 4];
      end
      if (busy_q) begin
        if (bcnt_q == '0) busy_q <= 1'b0;
        else              bcnt_q <= bcnt_q - 1'b1;
      end
      if (reg_ok && addr_i == OFF_PER) per_q <= wdata_i[CNT_W-1:0];
      if (drop) ovf_q <= 1'b1;
      else if (reg_ok && addr_i == OFF_STAT && wdata_i[STAT_OVF]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL: begin
        rdata_o[CTL_EN]                 = en_q;
        rdata_o[CTL_SRST]               = busy_q;
        rdata_o[CTL_PRE_LSB +: PRE_W]   = pre_q;
        rdata_o[CTL_SRC_LSB +: 2]       = src_q;
        rdata_o[CTL_LP_LSB +: 4]        = lp_q;
      end
      OFF_STAT: begin
        rdata_o[FILL_W-1:0] = fill_w;
        rdata_o[STAT_OVF]   = ovf_q;
      end
      OFF_SMPL: rdata_o[CNT_W-1:0] = active_w;
      OFF_PER:  rdata_o[CNT_W-1:0] = per_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pwm_fifo_ctrl_chk.sv
`timescale 1ns/1ps
module pwm_fifo_ctrl_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              pwm_i,
  input logic              busy_i,
  input logic [FILL_W-1:0] fill_i,
  input logic [CNT_W:0]    ctr_i,
  input logic [CNT_W-1:0]  active_i
);
  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FILL_W'(DEPTH)); // R3

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_i); // R10

  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ctr_i == '0)); // R10

  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i == '0) |-> !pwm_i); // R6

  AST_SRST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (fill_i == '0)); // R8

  AST_FILL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> ((fill_i == $past(fill_i)) || (fill_i == $past(fill_i) + 1'b1)
                 || (fill_i + 1'b1 == $past(fill_i)))); // R7
endmodule

bind pwm_fifo_ctrl pwm_fifo_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_q),
  .pwm_i    (pwm_o),
  .busy_i   (busy_q),
  .fill_i   (fill_w),
  .ctr_i    (ctr_w),
  .active_i (active_w)
);

// File: tb/tb_pwm_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_fifo_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int checks = 0, errors = 0, cyc = 0, tick_div = 1;
  bit chk_on = 0;

  pwm_fifo_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  bit m_en, m_run, m_busy, m_ovf;
  int m_pre, m_src, m_lp, m_per, m_bcnt, m_active, m_pcnt, m_ctr;
  int q[$];

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return 32'(m_en) | (32'(m_busy) << 3) | (32'(m_pre) << 4)
                   | (32'(m_src) << 16) | (32'(m_lp) << 22);
      5'h04: return 32'(q.size()) | (32'(m_ovf) << 4);
      5'h0C: return 32'(m_active);
      5'h10: return 32'(m_per);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_run = 0; m_busy = 0; m_ovf = 0; m_pre = 0; m_src = 0; m_lp = 0;
      m_per = 'hFFFE; m_bcnt = 0; m_active = 0; m_pcnt = 0; m_ctr = 0; q.delete();
    end else begin
      bit st, ad, pt, wp, wr, bo, fullp, setov;
      st = m_en && !m_run;
      ad = m_en && m_run;
      pt = ad && tick && (m_pcnt >= m_pre);
      wp = pt && (m_ctr >= m_per + 1);
      wr = req && we;
      bo = m_busy;
      fullp = (q.size() == 4);
      setov = 0;
      if (!m_en || st) begin m_pcnt = 0; m_ctr = 0; end
      else if (ad && tick) begin
        if (pt) begin m_pcnt = 0; m_ctr = wp ? 0 : m_ctr + 1; end
        else m_pcnt++;
      end
      if ((st || wp) && q.size() > 0) m_active = q.pop_front();
      if (wr && addr == 5'h0C && !bo) begin
        if (fullp) setov = 1; else q.push_back(int'(wdata[15:0]));
      end
      if (setov) m_ovf = 1;
      else if (wr && addr == 5'h04 && !bo && wdata[4]) m_ovf = 0;
      if (wr && addr == 5'h10 && !bo) m_per = int'(wdata[15:0]);
      m_run = m_en;
      if (bo) begin if (m_bcnt == 0) m_busy = 0; else m_bcnt--; end
      if (wr && addr == 5'h00) begin
        if (wdata[3]) begin
          m_en = 0; m_pre = 0; m_src = 0; m_lp = 0; m_busy = 1; m_bcnt = 3;
          q.delete(); m_active = 0; m_per = 'hFFFE; m_ovf = 0; m_run = 0;
          m_pcnt = 0; m_ctr = 0;
        end else begin
          m_en = wdata[0]; m_pre = int'(wdata[15:4]);
          m_src = int'(wdata[17:16]); m_lp = int'(wdata[25:22]);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // tick stimulus, per-cycle output compare (R5 R6 R7 R10), watchdog
  always @(negedge clk) begin
    cyc++;
    tick = ((cyc % tick_div) == 0);
    if (rst_n && chk_on)
      chk(pwm == (m_en && m_run && (m_ctr < m_active)), "R6 output vs model",
          int'(pwm), int'(m_en && m_run && (m_ctr < m_active)));
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd_now(input logic [4:0] a, input string tag, output logic [31:0] v);
    req = 0; we = 0; addr = a;
    #0.5;
    v = rdata;
    chk(rdata == m_read(a), tag, int'(rdata), int'(m_read(a)));
  endtask

  task automatic rd(input logic [4:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    rd_now(a, tag, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    int ones;
    idle(3);
    rst_n = 1;
    chk_on = 1;
    // R1 reset values
    rd(5'h00, "R1 ctrl", v);  chk(v == 0, "R1 ctrl const", int'(v), 0);
    rd(5'h04, "R1 stat", v);  chk(v == 0, "R1 stat const", int'(v), 0);
    rd(5'h0C, "R1 smpl", v);  chk(v == 0, "R1 smpl const", int'(v), 0);
    rd(5'h10, "R1 per", v);   chk(v == 32'hFFFE, "R1 per const", int'(v), 'hFFFE);
    rd(5'h08, "R1 hole", v);  chk(v == 0, "R1 hole const", int'(v), 0);
    // R2 field readback
    wr(5'h00, 32'h43C2_0052);
    rd(5'h00, "R2 ctrl", v);  chk(v == 32'h03C2_0050, "R2 ctrl const", int'(v), 32'h03C2_0050);
    wr(5'h00, 32'h0);
    // R3 R4 fill and overflow
    wr(5'h0C, 1); wr(5'h0C, 2); wr(5'h0C, 3); wr(5'h0C, 6); wr(5'h0C, 9);
    rd(5'h04, "R3 stat", v);  chk(v == 32'h14, "R3 full+ovf", int'(v), 'h14);
    wr(5'h04, 32'h0);
    rd(5'h04, "R4 stat", v);  chk(v == 32'h14, "R4 write0 keeps", int'(v), 'h14);
    wr(5'h04, 32'h10);
    rd(5'h04, "R4 stat", v);  chk(v == 32'h04, "R4 w1c", int'(v), 'h04);
    // R5 R6 R7 ramp, period 4 -> length 6
    wr(5'h10, 4);
    wr(5'h00, 1);
    idle(3);
    rd(5'h04, "R7 pop on enable", v); chk(v[2:0] == 3, "R7 fill after start", int'(v[2:0]), 3);
    idle(30);
    rd(5'h0C, "R7 active", v); chk(v == 6, "R7 last reused", int'(v), 6);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); chk(pwm == 1, "R6 full-length high", int'(pwm), 1);
    end
    wr(5'h0C, 0);
    idle(10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); chk(pwm == 0, "R6 zero sample low", int'(pwm), 0);
    end
    // R5 sparse ticks with prescaler
    tick_div = 3;
    wr(5'h10, 2);
    wr(5'h0C, 2); wr(5'h0C, 1); wr(5'h0C, 4);
    wr(5'h00, 32'h21);
    idle(150);
    rd(5'h04, "R5 stat", v);
    // R10 disable keeps fifo
    tick_div = 1;
    wr(5'h0C, 3); wr(5'h0C, 3);
    wr(5'h00, 32'h20);
    rd(5'h04, "R10 stat", v);
    idle(20);
    rd(5'h04, "R10 stat", v2); chk(v2 == v, "R10 fifo kept", int'(v2), int'(v));
    chk(pwm == 0, "R10 low", int'(pwm), 0);
    wr(5'h00, 32'h21);
    idle(40);
    // R8 reset pulse length and flush
    wr(5'h0C, 7);
    wr(5'h00, 32'h8);
    ones = 0;
    for (int i = 0; i < 6; i++) begin
      rd_now(5'h00, "R8 ctrl", v);
      if (v[3]) ones++;
      @(negedge clk);
    end
    chk(ones == 4, "R8 busy cycles", ones, 4);
    rd(5'h04, "R8 stat", v);  chk(v == 0, "R8 flushed", int'(v), 0);
    rd(5'h10, "R8 per", v);   chk(v == 32'hFFFE, "R8 per default", int'(v), 'hFFFE);
    // R9 writes during reset ignored
    wr(5'h10, 7); wr(5'h0C, 5);
    @(negedge clk); req = 1; we = 1; addr = 5'h00; wdata = 32'h8;
    @(negedge clk); addr = 5'h10; wdata = 3;
    @(negedge clk); addr = 5'h0C; wdata = 1;
    @(negedge clk); req = 0; we = 0;
    idle(6);
    rd(5'h10, "R9 per", v);   chk(v == 32'hFFFE, "R9 per ignored", int'(v), 'hFFFE);
    rd(5'h04, "R9 stat", v);  chk(v == 0, "R9 sample ignored", int'(v), 0);
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule